// File: doc/BRIEF.md
# Triple Programmable Down-Counter Timer

This block provides three independent down-counting timers behind a small word-addressed register bus. Each timer can be set through one control byte. The byte selects a prescale of 1, 16 or 256 applied to a shared tick-enable pulse, and it sets a 16-bit or 32-bit counting width. It also chooses how the counter reloads after it expires: to all ones, or from a stored reload value. A one-shot stop can be enabled as well.

On every expiry a timer sets its raw interrupt flag. Each timer drives its own interrupt line, which is the raw flag gated by the timer's interrupt-enable bit. Software clears the flag by writing the timer's clear register. A reload value can be written in two ways: together with the live count, or on its own so that it takes effect at the next reload.

Top module: `ttm_top`

## Requirements
- R1: After reset, each timer's control register reads 0x20, its raw status reads 0, its interrupt line is low, its value reads 0x0000FFFF in the default 16-bit width, and it reads 0xFFFFFFFF once 32-bit width is selected.
- R2: Address bits 9:8 pick the timer (0, 1 or 2; value 3 reads 0 and ignores writes). Address bits 4:2 pick the word: 0 load, 1 value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. Words 3 and 7 read 0.
- R3: Control bits are: 7 run, 6 periodic (1) or free-running (0), 5 interrupt enable, 3:2 prescale, 1 32-bit width (1) or 16-bit (0), 0 one-shot.
- R4: A write to word 0 sets both the reload value and the live count. A write to word 6 sets only the reload value, and the live count keeps its value. Word 0 and word 6 both read back the reload value.
- R5: The counter steps once per 1, 16 or 256 tick pulses for prescale codes 00, 01 and 10. Code 11 steps on every tick. A write to control or to word 0 restarts the prescale count.
- R6: A step taken while the value is 1 or 0 is an expiry. In periodic mode an expiry loads the reload value, so a reload of N expires every N steps.
- R7: In free-running mode an expiry loads all ones for the width: 0xFFFF or 0xFFFFFFFF.
- R8: In one-shot mode an expiry leaves the value at 0. The timer then stays at 0 and raises no further expiries until it is reloaded.
- R9: An expiry sets the raw flag. A write of any data to word 3 clears it, and an expiry in the same cycle wins. Masked status and the interrupt line both equal the raw flag AND control bit 5.
- R10: A timer with control bit 7 clear holds its value through any number of ticks. Writes to word 1 have no effect.
- R11: In 16-bit width only the low 16 bits count, and the value reads with its upper 16 bits zero even if the load data had them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable pulse shared by all timers |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high during a strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 3 | Per-timer interrupt lines |

## Verification
The hardest state to reach from the ports is a 256-way prescaler that is one tick away from stepping. The stimulus reaches it by loading 1 and issuing exactly 255 ticks, which leaves the value unchanged with no interrupt. A single further tick must then produce an expiry and a periodic reload. A finished one-shot timer is similarly tricky, because the absence of further expiries can only be seen after the flag has been cleared, so the bench clears the flag and keeps ticking before it checks that the flag stays low. The background-load case is only visible across a reload: the live count must ignore the new value until the next expiry and then pick it up.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
    localparam int CNT_W = 32;
    localparam int PRE_W = 8;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] psel;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = 8'h20;

    typedef enum logic [2:0] {
        W_LOAD   = 3'd0,
        W_VALUE  = 3'd1,
        W_CTRL   = 3'd2,
        W_ICLR   = 3'd3,
        W_RAW    = 3'd4,
        W_MASKED = 3'd5,
        W_BGLOAD = 3'd6,
        W_NONE   = 3'd7
    } word_e;

    function automatic logic [CNT_W-1:0] width_mask(input logic wide);
        return wide ? {CNT_W{1'b1}} : {{(CNT_W-16){1'b0}}, 16'hFFFF};
    endfunction

    function automatic logic [PRE_W-1:0] pre_term(input logic [1:0] psel);
        case (psel)
            2'b01:   return PRE_W'(15);
            2'b10:   return PRE_W'(255);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ttm_prescaler.sv
module ttm_prescaler
    import ttm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic [1:0] psel_i,
    output logic       step_o
);
    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] term;

    assign term   = pre_term(psel_i);
    assign step_o = run_i && tick_i && (pcnt_q == term);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            pcnt_q <= '0;
        else if (run_i && tick_i)
            pcnt_q <= (pcnt_q == term) ? '0 : pcnt_q + 1'b1;
    end

    // R5: a step always leaves the prescale count at its start
    assert_step_restart_R5: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (pcnt_q == '0));
endmodule

// File: rtl/ttm_channel.sv
module ttm_channel
    import ttm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_load_i,
    input  logic             wr_bg_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_iclr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] value_o,
    output logic             raw_o,
    output logic             irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             raw_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] cnt_d;
    logic             done;
    logic             run;
    logic             step;
    logic             expire;

    assign mask   = width_mask(ctrl_q.wide);
    assign cur    = cnt_q & mask;
    assign done   = ctrl_q.oneshot && (cur == '0);
    assign run    = ctrl_q.run && !done;
    assign expire = step && (cur <= CNT_W'(1));

    ttm_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (wr_ctrl_i || wr_load_i),
        .tick_i (tick_i),
        .run_i  (run),
        .psel_i (ctrl_q.psel),
        .step_o (step)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (wr_load_i)
            cnt_d = wdata_i;
        else if (expire) begin
            if (ctrl_q.oneshot)
                cnt_d = '0;
            else if (ctrl_q.periodic)
                cnt_d = load_q;
            else
                cnt_d = mask;
        end else if (step)
            cnt_d = (cur - 1'b1) & mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            load_q <= '0;
            cnt_q  <= {CNT_W{1'b1}};
            raw_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_ctrl_i)
                ctrl_q <= ctrl_t'(wdata_i[7:0]);
            if (wr_load_i || wr_bg_i)
                load_q <= wdata_i;
            if (expire)
                raw_q <= 1'b1;
            else if (wr_iclr_i)
                raw_q <= 1'b0;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign load_o  = load_q;
    assign value_o = cur;
    assign raw_o   = raw_q;
    assign irq_o   = raw_q && ctrl_q.irq_en;

    // R8: a finished one-shot stays at zero and raises nothing new
    assert_oneshot_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !wr_load_i) |=> (cnt_q == '0 && !$rose(raw_q)));
    // R10: a stopped timer keeps its count
    assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !wr_load_i) |=> $stable(cnt_q));
    // R9: the raw flag only rises after an expiry
    assert_raw_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> $past(expire));
    // R9: a clear without a competing expiry drops the flag
    assert_raw_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_iclr_i && !expire) |=> !raw_q);
endmodule

// File: rtl/ttm_top.sv
module ttm_top
    import ttm_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    localparam int TSEL_LO = 8;
    localparam int TSEL_W  = ADDR_W - TSEL_LO;

    logic [TSEL_W-1:0] tsel;
    word_e             wsel;
    logic              wr_go;

    ctrl_t            ctrl_a  [NUM_TMR];
    logic [CNT_W-1:0] load_a  [NUM_TMR];
    logic [CNT_W-1:0] value_a [NUM_TMR];
    logic             raw_a   [NUM_TMR];

    assign tsel  = bus_addr[ADDR_W-1:TSEL_LO];
    assign wsel  = word_e'(bus_addr[4:2]);
    assign wr_go = bus_sel && bus_wr;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic hit;
        assign hit = wr_go && (tsel == TSEL_W'(i));

        ttm_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick_i    (tick_en),
            .wr_load_i (hit && wsel == W_LOAD),
            .wr_bg_i   (hit && wsel == W_BGLOAD),
            .wr_ctrl_i (hit && wsel == W_CTRL),
            .wr_iclr_i (hit && wsel == W_ICLR),
            .wdata_i   (bus_wdata),
            .ctrl_o    (ctrl_a[i]),
            .load_o    (load_a[i]),
            .value_o   (value_a[i]),
            .raw_o     (raw_a[i]),
            .irq_o     (irq[i])
        );

        // R9: an interrupt line is only high with its enable bit set
        assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> (raw_a[i] && ctrl_a[i].irq_en));
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (tsel == TSEL_W'(i)) begin
                case (wsel)
                    W_LOAD, W_BGLOAD: bus_rdata = load_a[i];
                    W_VALUE:          bus_rdata = value_a[i];
                    W_CTRL:           bus_rdata = {{(CNT_W-8){1'b0}}, ctrl_a[i]};
                    W_RAW:            bus_rdata = {{(CNT_W-1){1'b0}}, raw_a[i]};
                    W_MASKED:         bus_rdata = {{(CNT_W-1){1'b0}}, raw_a[i] && ctrl_a[i].irq_en};
                    default:          bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/sim_ttm_top.sv
module sim_ttm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ttm_top u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam int NV = 11;
    // timer, load, control, ticks, expected value, expected raw
    localparam logic [1:0]  V_T  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1, 2, 0, 1};
    localparam logic [31:0] V_LD [NV] = '{10, 5, 5, 3, 3, 2, 40, 32'h10003, 100, 1, 7};
    localparam logic [7:0]  V_C  [NV] = '{8'hE0, 8'hE0, 8'hE0, 8'hA0, 8'hA2, 8'hE1,
                                          8'hE4, 8'hE0, 8'h60, 8'hE8, 8'hEC};
    localparam int          V_N  [NV] = '{3, 5, 7, 3, 3, 5, 32, 2, 10, 255, 2};
    localparam logic [31:0] V_EV [NV] = '{7, 5, 3, 32'hFFFF, 32'hFFFFFFFF, 0, 38, 1, 100, 1, 5};
    localparam logic        V_ER [NV] = '{0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0};
    localparam string       V_RQ [NV] = '{"R6", "R6", "R6", "R7", "R7", "R8",
                                          "R5", "R11", "R10", "R5", "R5"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] t, input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = {t, 3'b000, w, 2'b00};
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] t, input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = {t, 3'b000, w, 2'b00};
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic setup(input logic [1:0] t, input logic [31:0] ld, input logic [7:0] c);
        wr(t, 3'd2, 32'h0);
        wr(t, 3'd0, ld);
        wr(t, 3'd2, {24'h0, c});
        wr(t, 3'd3, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int t = 0; t < 3; t++) begin
            rd(t[1:0], 3'd2, d); chk("R1 ctrl", d, 32'h20);
            rd(t[1:0], 3'd1, d); chk("R1 value16", d, 32'hFFFF);
            rd(t[1:0], 3'd4, d); chk("R1 raw", d, 0);
        end
        chk("R1 irq", {29'h0, irq}, 0);
        wr(2'd1, 3'd2, 32'h22);
        rd(2'd1, 3'd1, d); chk("R1 value32", d, 32'hFFFFFFFF);

        // R2 unused slots read zero
        rd(2'd3, 3'd2, d); chk("R2 timer3", d, 0);
        rd(2'd0, 3'd7, d); chk("R2 word7", d, 0);
        rd(2'd0, 3'd3, d); chk("R2 word3", d, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            setup(V_T[v], V_LD[v], V_C[v]);
            ticks(V_N[v]);
            rd(V_T[v], 3'd1, d); chk({V_RQ[v], " value"}, d, V_EV[v]);
            rd(V_T[v], 3'd4, d); chk({V_RQ[v], " raw"}, d, {31'h0, V_ER[v]});
        end

        // R5 div256: one more tick triggers expiry and reload (R6)
        setup(2'd0, 1, 8'hE8);
        ticks(255);
        rd(2'd0, 3'd4, d); chk("R5 no step at 255", d, 0);
        ticks(1);
        rd(2'd0, 3'd1, d); chk("R5 step at 256", d, 1);
        rd(2'd0, 3'd4, d); chk("R5 raw at 256", d, 1);

        // R9 masking and clear; R3 control readback
        setup(2'd1, 2, 8'hE0);
        ticks(2);
        rd(2'd1, 3'd5, d); chk("R9 masked on", d, 1);
        chk("R9 irq on", {31'h0, irq[1]}, 1);
        wr(2'd1, 3'd2, 32'hC0);
        rd(2'd1, 3'd2, d); chk("R3 ctrl readback", d, 32'hC0);
        rd(2'd1, 3'd5, d); chk("R9 masked off", d, 0);
        chk("R9 irq off", {31'h0, irq[1]}, 0);
        rd(2'd1, 3'd4, d); chk("R9 raw kept", d, 1);
        wr(2'd1, 3'd3, 32'h1234);
        rd(2'd1, 3'd4, d); chk("R9 raw cleared", d, 0);

        // R8 one-shot: no further expiry after clear
        setup(2'd2, 1, 8'hE1);
        ticks(1);
        rd(2'd2, 3'd4, d); chk("R8 first expiry", d, 1);
        wr(2'd2, 3'd3, 32'h0);
        ticks(4);
        rd(2'd2, 3'd4, d); chk("R8 no re-expiry", d, 0);
        rd(2'd2, 3'd1, d); chk("R8 held zero", d, 0);

        // R4 background load and R10 ignored value write
        setup(2'd0, 9, 8'hE0);
        wr(2'd0, 3'd6, 32'd4);
        rd(2'd0, 3'd1, d); chk("R4 count kept", d, 9);
        rd(2'd0, 3'd0, d); chk("R4 reload read", d, 4);
        wr(2'd0, 3'd1, 32'h55);
        rd(2'd0, 3'd1, d); chk("R10 value write ignored", d, 9);
        ticks(9);
        rd(2'd0, 3'd1, d); chk("R4 bg reload used", d, 4);
        wr(2'd3, 3'd0, 32'h77);
        rd(2'd0, 3'd1, d); chk("R2 timer3 write ignored", d, 4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule